// File: doc/BRIEF.md
# Load-Use Hazard Monitor

A debug-only observer for a five-stage RISC core that has no hardware interlock on loads. In such a core the register written by a load holds an undefined value for the one instruction that directly follows the load. Software must never read the register in that slot. The monitor watches the stream of retired instructions and reports every instruction that breaks this rule.

Each cycle the core presents a valid strobe, a two-bit operation class, a destination index and two source indices. The monitor remembers the destination of a load for exactly one valid cycle. It compares that destination against the source registers that the next instruction actually reads. On a match it raises a one-cycle pulse that carries the register index, and it advances a saturating error counter. The monitor never stalls the core and never alters execution.

Top module: `ld_use_monitor`

## Requirements
- R1: Operation classes are encoded 2'b00 ALU (reads src_a and src_b), 2'b01 LOAD (reads src_a as base, writes dst_reg), 2'b10 STORE (reads src_a as base and src_b as data), 2'b11 MISC (reads nothing). An ALU instruction that directly follows a load and reads that load's destination through either source is flagged.
- R2: Only the single instruction directly after a load is checked. A read of the load's destination two or more instructions later is not flagged.
- R3: Two loads in a row are flagged only when the second load's base (src_a) equals the first load's destination. The second load's src_b and dst_reg are never compared. The second load becomes the pending load for the instruction that follows it.
- R4: A store directly after a load is flagged when its data register (src_b) or its base (src_a) equals the load's destination.
- R5: A store followed by a load is never flagged, because a store writes no register.
- R6: A load whose destination is register 0 never leads to a hazard.
- R7: A cycle with ins_valid low between a load and the next valid instruction clears the pending check.
- R8: hazard_pulse is high for exactly the one cycle after the edge that accepts the offending instruction. During that cycle hazard_reg holds the load's destination index. hazard_reg is 0 whenever hazard_pulse is low.
- R9: err_count rises by one in the same cycle as each hazard pulse, stays unchanged otherwise, and saturates at its all-ones value.
- R10: While reset (rst_n low) is asserted, hazard_pulse, hazard_reg and err_count are all 0, and no load is pending.
- R11: A MISC instruction directly after a load is never flagged, whatever its source fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | A retired instruction is present this cycle |
| op_class | input | 2 | Operation class (see R1) |
| dst_reg | input | REG_W | Destination register index |
| src_a | input | REG_W | First source index (base for loads and stores) |
| src_b | input | REG_W | Second source index (data for stores) |
| hazard_pulse | output | 1 | One-cycle load-use violation report |
| hazard_reg | output | REG_W | Register involved in the reported violation |
| err_count | output | CNT_W | Saturating count of violations |

## Verification
The bench attacks the cases where a sloppy comparison goes wrong. If a load's unused src_b or the fields of a MISC instruction were compared, the design would give false reports. If a pending load survived a bubble or was compared two instructions later, the design would report stale hazards. A design that ignored register 0 handling would report a hazard after a load to register 0. The bench also chains a load on a load, where the second load must be both a victim and the new pending load. Finally it drives the counter past all-ones, which would show a wrap-around to zero.

// File: rtl/ld_use_monitor.sv
module ld_use_monitor #(
  parameter int REG_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [1:0]       op_class,
  input  logic [REG_W-1:0] dst_reg,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             hazard_pulse,
  output logic [REG_W-1:0] hazard_reg,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [1:0] OP_ALU   = 2'b00;
  localparam logic [1:0] OP_LOAD  = 2'b01;
  localparam logic [1:0] OP_STORE = 2'b10;
  localparam logic [1:0] OP_MISC  = 2'b11;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             pend_v;
  logic [REG_W-1:0] pend_r;
  logic             reads_a, reads_b, hit, arm;

  assign reads_a = (op_class != OP_MISC);
  assign reads_b = (op_class == OP_ALU) || (op_class == OP_STORE);
  assign hit     = ins_valid && pend_v &&
                   ((reads_a && src_a == pend_r) || (reads_b && src_b == pend_r));
  assign arm     = ins_valid && (op_class == OP_LOAD) && (dst_reg != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v       <= 1'b0;
      pend_r       <= '0;
      hazard_pulse <= 1'b0;
      hazard_reg   <= '0;
      err_count    <= '0;
    end else begin
      pend_v       <= arm;
      pend_r       <= arm ? dst_reg : '0;
      hazard_pulse <= hit;
      hazard_reg   <= hit ? pend_r : '0;
      if (hit && err_count != CNT_MAX)
        err_count <= err_count + 1'b1;
    end
  end
endmodule

module ld_use_monitor_chk #(
  parameter int REG_W = 5,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic [1:0]       op_class,
  input logic             hazard_pulse,
  input logic [REG_W-1:0] hazard_reg,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_REG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_pulse |-> hazard_reg != '0); // R6
  AST_REG_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hazard_pulse |-> hazard_reg == '0); // R8
  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> !hazard_pulse); // R7
  AST_MISC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && op_class == 2'b11) |=> !hazard_pulse); // R11
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hazard_pulse |-> $stable(err_count)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hazard_pulse && $past(err_count) != CNT_MAX) |-> err_count == CNT_W'($past(err_count) + 1'b1)); // R9
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_count) == CNT_MAX) |-> err_count == CNT_MAX); // R9
endmodule

bind ld_use_monitor ld_use_monitor_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .op_class(op_class),
  .hazard_pulse(hazard_pulse), .hazard_reg(hazard_reg), .err_count(err_count)
);

// File: tb/ld_use_monitor_tb_top.sv
module ld_use_monitor_tb_top;
  localparam int REG_W = 5;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, ins_valid = 0;
  logic [1:0] op_class = 0;
  logic [REG_W-1:0] dst_reg = 0, src_a = 0, src_b = 0;
  logic hazard_pulse;
  logic [REG_W-1:0] hazard_reg;
  logic [CNT_W-1:0] err_count;

  always #5 clk = ~clk;

  ld_use_monitor #(.REG_W(REG_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .op_class(op_class),
    .dst_reg(dst_reg), .src_a(src_a), .src_b(src_b),
    .hazard_pulse(hazard_pulse), .hazard_reg(hazard_reg), .err_count(err_count));

  typedef struct { logic hz; int rg; int cnt; string tag; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit m_pend = 0; int m_reg = 0; int m_cnt = 0;
  bit done = 0;

  task automatic issue(input bit v, input logic [1:0] op, input int d, input int a, input int b, input string tag);
    exp_t e;
    bit ra, rb, h;
    @(negedge clk);
    ins_valid = v; op_class = op; dst_reg = d[REG_W-1:0]; src_a = a[REG_W-1:0]; src_b = b[REG_W-1:0];
    ra = (op != 2'b11); rb = (op == 2'b00) || (op == 2'b10);
    h = v && m_pend && ((ra && a == m_reg) || (rb && b == m_reg));
    if (h && m_cnt < CMAX) m_cnt++;
    e.hz = h; e.rg = h ? m_reg : 0; e.cnt = m_cnt; e.tag = tag;
    q.push_back(e);
    m_pend = v && op == 2'b01 && d != 0;
    m_reg  = m_pend ? d : 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (hazard_pulse !== e.hz || int'(hazard_reg) != e.rg || int'(err_count) != e.cnt) begin
        n_bad++;
        $display("FAIL %s: pulse/reg/count got %0b/%0d/%0d expected %0b/%0d/%0d",
                 e.tag, hazard_pulse, hazard_reg, err_count, e.hz, e.rg, e.cnt);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (hazard_pulse !== 0 || hazard_reg !== 0 || err_count !== 0) begin
      n_bad++;
      $display("FAIL R10: reset outputs got %0b/%0d/%0d expected 0/0/0", hazard_pulse, hazard_reg, err_count);
    end
    rst_n = 1;
    // R1
    issue(1, 2'b01, 5, 1, 0, "R1 load r5");
    issue(1, 2'b00, 9, 5, 2, "R1 alu reads r5 via a");
    issue(1, 2'b01, 6, 1, 0, "R1 load r6");
    issue(1, 2'b00, 9, 3, 6, "R1 alu reads r6 via b");
    issue(1, 2'b01, 7, 1, 0, "R1 load r7");
    issue(1, 2'b00, 9, 2, 3, "R1 alu unrelated");
    // R2
    issue(1, 2'b01, 8, 1, 0, "R2 load r8");
    issue(1, 2'b00, 9, 1, 2, "R2 safe slot");
    issue(1, 2'b00, 9, 8, 8, "R2 later read of r8");
    // R3
    issue(1, 2'b01, 9, 1, 0, "R3 load r9");
    issue(1, 2'b01, 10, 9, 0, "R3 load base r9");
    issue(1, 2'b00, 4, 10, 0, "R3 chained read r10");
    issue(1, 2'b01, 11, 1, 0, "R3 load r11");
    issue(1, 2'b01, 11, 2, 11, "R3 load src_b/dst ignored");
    // R4
    issue(1, 2'b01, 13, 1, 0, "R4 load r13");
    issue(1, 2'b10, 0, 2, 13, "R4 store data r13");
    issue(1, 2'b01, 12, 1, 0, "R4 load r12");
    issue(1, 2'b10, 0, 12, 3, "R4 store base r12");
    // R5
    issue(1, 2'b10, 4, 4, 4, "R5 store");
    issue(1, 2'b01, 4, 4, 4, "R5 load after store");
    issue(1, 2'b11, 0, 0, 0, "R5 misc");
    // R6
    issue(1, 2'b01, 0, 1, 0, "R6 load r0");
    issue(1, 2'b00, 9, 0, 0, "R6 alu reads r0");
    // R7
    issue(1, 2'b01, 14, 1, 0, "R7 load r14");
    issue(0, 2'b00, 0, 0, 0, "R7 bubble");
    issue(1, 2'b00, 9, 14, 14, "R7 read after bubble");
    // R11
    issue(1, 2'b01, 15, 1, 0, "R11 load r15");
    issue(1, 2'b11, 15, 15, 15, "R11 misc fields r15");
    // R8 consecutive hazards then quiet
    issue(1, 2'b01, 16, 1, 0, "R8 load r16");
    issue(1, 2'b01, 17, 16, 0, "R8 load base r16");
    issue(1, 2'b10, 0, 1, 17, "R8 store data r17");
    issue(1, 2'b00, 9, 1, 2, "R8 pulse ends");
    // R9 saturation
    for (int i = 0; i < 12; i++) begin
      issue(1, 2'b01, 3, 1, 0, "R9 load r3");
      issue(1, 2'b00, 9, 3, 0, "R9 hazard toward saturation");
    end
    issue(0, 2'b00, 0, 0, 0, "R9 idle hold");
    issue(0, 2'b00, 0, 0, 0, "R9 idle hold");
    @(negedge clk);
    ins_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule